// File: doc/BRIEF.md
# Shared-Memory Channel Controller

This block connects a hardware coprocessor to software-style FIFO channels that live in shared memory. Each channel is a circular buffer of items plus a small header of state words, and the same buffer may be touched by software tasks elsewhere in the system. The controller is a bus master: it claims a channel's spin lock with an atomic swap, fetches the channel's index and fill count, moves as many items as the buffer and the coprocessor allow, writes the new index and fill count back and then frees the lock.

A parameterised number of channels share one bus port. Each channel is fixed at build time to one direction: a producer channel takes items from the coprocessor and stores them into memory, and a consumer channel fetches items from memory and hands them to the coprocessor. Software places each channel by setting its base word address. Access never blocks: an attempt on a full or empty channel still takes and frees the lock, moves nothing and reports a count of zero, and the channel then gives way to the others.

Top module: `chl_ctrl`

## Requirements
- R1: A channel's image at word address B holds the lock at B+0, the read index at B+1, the write index at B+2, the fill count at B+3 and item k at B+4+k; a producer channel updates B+2, a consumer channel updates B+1, both update B+3.
- R2: Each transfer starts with an atomic swap (bus_swap=1, bus_we=1, bus_wdata=1) on B+0; only a returned value of zero lets the controller issue other accesses, and the lock is freed by writing 0 to B+0 as the last access, after both state words have been acknowledged.
- R3: When the swap returns a nonzero value the controller issues no further access for that attempt and keeps bus_req low for 16 cycles after the acknowledge; with no other channel pending the next swap is acknowledged exactly 19 cycles after the failed one.
- R4: On a producer channel each stored item is taken from the coprocessor with a one-cycle cp_wready pulse in the cycle its memory write is acknowledged; items are stored while free space remains and cp_wvalid stays high.
- R5: On a consumer channel an item is read only while cp_rready is high, and is presented on cp_rdata with a one-cycle cp_rvalid pulse in the cycle its bus read is acknowledged, in FIFO order.
- R6: An attempt on a full producer channel or an empty consumer channel moves nothing, still frees the lock and reports a count of zero.
- R7: Read and write indices advance by one per item and wrap from DEPTH-1 to 0; the fill count goes up by the count on a producer channel and down by it on a consumer channel.
- R8: One cycle after the releasing write is acknowledged, done pulses for one cycle with done_ch naming the channel and done_cnt the number of items moved (never above DEPTH).
- R9: Pending channels (producer: cp_wvalid high; consumer: cp_rready high) are served round-robin; after any attempt, including one that moved nothing or lost the lock, the search restarts at the next channel.
- R10: After reset bus_req, done, every cp_wready and every cp_rvalid are low.
- R11: Once bus_req rises, bus_addr, bus_we, bus_swap and bus_wdata hold until bus_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | NCH*AW | Base word address of each channel, channel c at bits [c*AW +: AW] |
| cp_wvalid | input | NCH | Producer item offered by the coprocessor, per channel |
| cp_wdata | input | NCH*DW | Producer item data, per channel |
| cp_wready | output | NCH | Producer item taken, per channel |
| cp_rready | input | NCH | Coprocessor can accept a consumer item, per channel |
| cp_rvalid | output | NCH | Consumer item presented, per channel |
| cp_rdata | output | DW | Consumer item data, shared by all channels |
| bus_req | output | 1 | Bus access request |
| bus_swap | output | 1 | Access is an atomic swap |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Word address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| bus_ack | input | 1 | One-cycle access acknowledge |
| done | output | 1 | Attempt finished and lock freed |
| done_ch | output | CHW | Channel of the finished attempt |
| done_cnt | output | CNTW | Items moved by the finished attempt |

## Verification
The bench memory acknowledges each request one cycle after it sees it with read data registered, so cp_wready and cp_rvalid belong to the acknowledge cycle and are sampled on the falling edge of that cycle, done is sampled one cycle after the releasing write's acknowledge, and a lost lock is measured as a 19-cycle distance between swap acknowledges. Memory contents (indices, fill count, lock, stored items) are only read once the bench has waited well past the last done of a scenario, so no check races the write-back. Consumer items are compared against a queue of expected values filled before the channel is enabled, and the round-robin order is checked on the logged sequence of done_ch values.

// File: rtl/chl_pkg.sv
package chl_pkg;

    // Word offsets inside a channel image
    localparam int OFF_LOCK = 0;
    localparam int OFF_RIDX = 1;
    localparam int OFF_WIDX = 2;
    localparam int OFF_FILL = 3;
    localparam int OFF_DATA = 4;

    // Idle cycles after a lost lock
    localparam int BACKOFF_CYC = 16;
    localparam int BOW         = $clog2(BACKOFF_CYC + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOCK,
        ST_BACK,
        ST_GIDX,
        ST_GFILL,
        ST_XCHK,
        ST_XMOV,
        ST_PIDX,
        ST_PFILL,
        ST_UNLK
    } eng_state_t;

endpackage

// File: rtl/chl_arbiter.sv
module chl_arbiter #(
    parameter int NCH = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pend,
    input  logic           advance,
    input  logic [CHW-1:0] served,
    output logic           grant_any,
    output logic [CHW-1:0] grant_idx
);

    logic [CHW-1:0] ptr;

    // First pending channel at or after the pointer
    always_comb begin
        grant_any = 1'b0;
        grant_idx = '0;
        for (int k = 0; k < NCH; k++) begin
            int j;
            j = (int'(ptr) + k) % NCH;
            if (!grant_any && pend[j]) begin
                grant_any = 1'b1;
                grant_idx = CHW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (int'(served) == NCH - 1) ? '0 : served + CHW'(1);
        end
    end

endmodule

// File: rtl/chl_engine.sv
module chl_engine
    import chl_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int DW    = 16,
    parameter int AW    = 8,
    parameter int DEPTH = 4,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [CHW-1:0]  start_ch,
    input  logic            start_wr,
    input  logic [AW-1:0]   start_base,
    input  logic            pend,
    input  logic [DW-1:0]   item_in,
    output logic            bus_req,
    output logic            bus_swap,
    output logic            bus_we,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            bus_ack,
    output logic            idle,
    output logic            take,
    output logic            advance,
    output logic [CHW-1:0]  cur_ch,
    output logic            done,
    output logic [CHW-1:0]  done_ch,
    output logic [CNTW-1:0] done_cnt
);

    typedef struct packed {
        logic [CHW-1:0]  ch;
        logic            wr;
        logic [AW-1:0]   base;
        logic [IW-1:0]   idx;
        logic [CNTW-1:0] fill;
        logic [CNTW-1:0] avail;
        logic [CNTW-1:0] cnt;
    } ctx_t;

    eng_state_t     st;
    ctx_t           cx;
    logic [BOW-1:0] bo;

    logic [AW-1:0]   idx_addr;
    logic [CNTW-1:0] fill_rd;
    logic [CNTW-1:0] fill_new;
    logic [IW-1:0]   idx_next;
    logic            lock_lost;

    assign idx_addr  = cx.base + AW'(cx.wr ? OFF_WIDX : OFF_RIDX);
    assign fill_rd   = bus_rdata[CNTW-1:0];
    assign fill_new  = cx.wr ? cx.fill + cx.cnt : cx.fill - cx.cnt;
    assign idx_next  = (int'(cx.idx) == DEPTH - 1) ? '0 : cx.idx + IW'(1);
    assign lock_lost = (st == ST_LOCK) && bus_ack && (bus_rdata != '0);

    assign idle    = (st == ST_IDLE);
    assign take    = (st == ST_XMOV) && bus_ack;
    assign advance = lock_lost || ((st == ST_UNLK) && bus_ack);
    assign cur_ch  = cx.ch;

    // Bus command decoded from the state; held until acknowledge
    always_comb begin
        bus_req   = 1'b0;
        bus_swap  = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = cx.base;
        bus_wdata = '0;
        unique case (st)
            ST_LOCK: begin
                bus_req   = 1'b1;
                bus_swap  = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = DW'(1);
            end
            ST_GIDX: begin
                bus_req  = 1'b1;
                bus_addr = idx_addr;
            end
            ST_GFILL: begin
                bus_req  = 1'b1;
                bus_addr = cx.base + AW'(OFF_FILL);
            end
            ST_XMOV: begin
                bus_req   = 1'b1;
                bus_we    = cx.wr;
                bus_addr  = cx.base + AW'(OFF_DATA) + AW'(cx.idx);
                bus_wdata = item_in;
            end
            ST_PIDX: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = idx_addr;
                bus_wdata = DW'(cx.idx);
            end
            ST_PFILL: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = cx.base + AW'(OFF_FILL);
                bus_wdata = DW'(fill_new);
            end
            ST_UNLK: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cx       <= '0;
            bo       <= '0;
            done     <= 1'b0;
            done_ch  <= '0;
            done_cnt <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    cx.ch   <= start_ch;
                    cx.wr   <= start_wr;
                    cx.base <= start_base;
                    st      <= ST_LOCK;
                end
                ST_LOCK: if (bus_ack) begin
                    if (lock_lost) begin
                        bo <= BOW'(BACKOFF_CYC - 1);
                        st <= ST_BACK;
                    end else begin
                        st <= ST_GIDX;
                    end
                end
                ST_BACK: begin
                    if (bo == '0) st <= ST_IDLE;
                    else          bo <= bo - BOW'(1);
                end
                ST_GIDX: if (bus_ack) begin
                    cx.idx <= bus_rdata[IW-1:0];
                    st     <= ST_GFILL;
                end
                ST_GFILL: if (bus_ack) begin
                    cx.fill  <= fill_rd;
                    cx.avail <= cx.wr ? CNTW'(DEPTH) - fill_rd : fill_rd;
                    cx.cnt   <= '0;
                    st       <= ST_XCHK;
                end
                ST_XCHK: begin
                    if ((cx.cnt < cx.avail) && pend) st <= ST_XMOV;
                    else                              st <= ST_PIDX;
                end
                ST_XMOV: if (bus_ack) begin
                    cx.idx <= idx_next;
                    cx.cnt <= cx.cnt + CNTW'(1);
                    st     <= ST_XCHK;
                end
                ST_PIDX:  if (bus_ack) st <= ST_PFILL;
                ST_PFILL: if (bus_ack) st <= ST_UNLK;
                ST_UNLK: if (bus_ack) begin
                    done     <= 1'b1;
                    done_ch  <= cx.ch;
                    done_cnt <= cx.cnt;
                    st       <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/chl_ctrl.sv
module chl_ctrl #(
    parameter int NCH = 2,
    parameter int DW  = 16,
    parameter int AW  = 8,
    parameter int DEPTH = 4,
    parameter logic [NCH-1:0] CH_WRITE = 2'b01,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH*AW-1:0] cfg_base,
    input  logic [NCH-1:0]    cp_wvalid,
    input  logic [NCH*DW-1:0] cp_wdata,
    output logic [NCH-1:0]    cp_wready,
    input  logic [NCH-1:0]    cp_rready,
    output logic [NCH-1:0]    cp_rvalid,
    output logic [DW-1:0]     cp_rdata,
    output logic              bus_req,
    output logic              bus_swap,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_ack,
    output logic              done,
    output logic [CHW-1:0]    done_ch,
    output logic [CNTW-1:0]   done_cnt
);

    logic [NCH-1:0] pend_vec;
    logic           grant_any;
    logic [CHW-1:0] grant_idx;
    logic           eng_idle;
    logic           take;
    logic           advance;
    logic [CHW-1:0] cur_ch;
    logic           pend_sel;
    logic [DW-1:0]  item_sel;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (CH_WRITE[c]) begin : g_prod
            assign pend_vec[c]  = cp_wvalid[c];
            assign cp_wready[c] = take && (cur_ch == CHW'(c));
            assign cp_rvalid[c] = 1'b0;
        end else begin : g_cons
            assign pend_vec[c]  = cp_rready[c];
            assign cp_wready[c] = 1'b0;
            assign cp_rvalid[c] = take && (cur_ch == CHW'(c));
        end
    end

    assign pend_sel = pend_vec[cur_ch];
    assign item_sel = cp_wdata[cur_ch*DW +: DW];
    assign cp_rdata = bus_rdata;

    chl_arbiter #(.NCH(NCH)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend_vec),
        .advance   (advance),
        .served    (cur_ch),
        .grant_any (grant_any),
        .grant_idx (grant_idx)
    );

    chl_engine #(.NCH(NCH), .DW(DW), .AW(AW), .DEPTH(DEPTH)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (eng_idle && grant_any),
        .start_ch   (grant_idx),
        .start_wr   (CH_WRITE[grant_idx]),
        .start_base (cfg_base[grant_idx*AW +: AW]),
        .pend       (pend_sel),
        .item_in    (item_sel),
        .bus_req    (bus_req),
        .bus_swap   (bus_swap),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_ack    (bus_ack),
        .idle       (eng_idle),
        .take       (take),
        .advance    (advance),
        .cur_ch     (cur_ch),
        .done       (done),
        .done_ch    (done_ch),
        .done_cnt   (done_cnt)
    );

endmodule

// File: rtl/chl_ctrl_chk.sv
module chl_ctrl_chk #(
    parameter int NCH = 2,
    parameter int DW  = 16,
    parameter int AW  = 8,
    parameter int DEPTH = 4,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic [NCH-1:0]  cp_wready,
    input logic [NCH-1:0]  cp_rvalid,
    input logic            bus_req,
    input logic            bus_swap,
    input logic            bus_we,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic            bus_ack,
    input logic            done,
    input logic [CNTW-1:0] done_cnt
);

    logic       holding;
    logic [4:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            holding <= 1'b0;
            gap     <= '0;
        end else begin
            if (bus_ack && bus_swap && bus_rdata == '0) holding <= 1'b1;
            else if (done)                             holding <= 1'b0;
            if (bus_ack && bus_swap && bus_rdata != '0) gap <= 5'd16;
            else if (gap != '0)                        gap <= gap - 5'd1;
        end
    end

    // R2: non-swap accesses only while the lock is held
    p_lock_held_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_swap) |-> holding);

    // R2: the attempt ends right after a zero written and acknowledged
    p_unlock_last_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_ack && bus_we && !bus_swap && bus_wdata == '0));

    // R3: silent bus during back-off
    p_backoff_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (gap != '0) |-> !bus_req);

    // R4: one coprocessor handshake at a time
    p_one_port_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cp_wready, cp_rvalid}));

    // R5: consumer items only with an acknowledged read
    p_rvalid_ack_r5: assert property (@(posedge clk) disable iff (rst)
        (|cp_rvalid) |-> (bus_ack && !bus_we));

    // R8: count never exceeds depth
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_cnt <= CNTW'(DEPTH)));

    // R11: request held stable until acknowledged
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_swap) && $stable(bus_wdata)));

endmodule

bind chl_ctrl chl_ctrl_chk #(.NCH(NCH), .DW(DW), .AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cp_wready (cp_wready),
    .cp_rvalid (cp_rvalid),
    .bus_req   (bus_req),
    .bus_swap  (bus_swap),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .done      (done),
    .done_cnt  (done_cnt)
);

// File: tb/chl_ctrl_test.sv
module chl_ctrl_test;

    localparam int NCH = 2, DW = 16, AW = 8, DEPTH = 4;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int B0 = 0, B1 = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic [NCH*AW-1:0] cfg_base;
    logic [NCH-1:0]    cp_wvalid = '0, cp_rready = '0;
    logic [NCH*DW-1:0] cp_wdata = '0;
    logic [NCH-1:0]    cp_wready, cp_rvalid;
    logic [DW-1:0]     cp_rdata;
    logic bus_req, bus_swap, bus_we, bus_ack = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata = '0;
    logic done;
    logic [0:0] done_ch;
    logic [CNTW-1:0] done_cnt;

    always #10 clk = ~clk;

    chl_ctrl #(.NCH(NCH), .DW(DW), .AW(AW), .DEPTH(DEPTH), .CH_WRITE(2'b01)) uut (
        .clk(clk), .rst(rst), .cfg_base(cfg_base),
        .cp_wvalid(cp_wvalid), .cp_wdata(cp_wdata), .cp_wready(cp_wready),
        .cp_rready(cp_rready), .cp_rvalid(cp_rvalid), .cp_rdata(cp_rdata),
        .bus_req(bus_req), .bus_swap(bus_swap), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .done(done), .done_ch(done_ch), .done_cnt(done_cnt));

    assign cfg_base = {AW'(B1), AW'(B0)};

    // Shared memory model: acknowledge one cycle after request
    logic [DW-1:0] mem [32];
    always @(posedge clk) begin
        if (rst) begin
            bus_ack <= 1'b0;
        end else begin
            bus_ack <= bus_req && !bus_ack;
            if (bus_req && !bus_ack) begin
                if (bus_swap) begin
                    bus_rdata <= mem[bus_addr[4:0]];
                    mem[bus_addr[4:0]] <= bus_wdata;
                end else if (bus_we) begin
                    mem[bus_addr[4:0]] <= bus_wdata;
                end else begin
                    bus_rdata <= mem[bus_addr[4:0]];
                end
            end
        end
    end

    int errors = 0, checks = 0;
    int cyc = 0;
    int wtake = 0, rgot = 0, zero_done[2] = '{0, 0}, tot[2] = '{0, 0};
    int last_fail = -1, gap_seen = -1;
    logic [DW-1:0] exp_q[$];
    int dlog[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: scoreboard for consumer items, done log, swap timing
    always @(negedge clk) begin
        if (!rst) begin
            if (cp_rvalid[1]) begin
                rgot++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected item", int'(cp_rdata), -1);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(cp_rdata == e, "R5 item order", int'(cp_rdata), int'(e));
                end
            end
            if (cp_wready[0]) wtake++;
            if (done) begin
                dlog.push_back(int'(done_ch));
                tot[done_ch] += int'(done_cnt);
                if (done_cnt == '0) zero_done[done_ch]++;
            end
            if (bus_ack && bus_swap && bus_rdata != '0) begin
                if (last_fail >= 0 && gap_seen < 0) gap_seen = cyc - last_fail;
                last_fail = cyc;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: offer producer items on channel 0
    task automatic push_items(input int n, input logic [DW-1:0] first);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cp_wvalid[0] = 1'b1;
            cp_wdata[DW-1:0] = first + DW'(i);
            do @(negedge clk); while (!cp_wready[0]);
        end
        @(negedge clk);
        cp_wvalid[0] = 1'b0;
    endtask

    task automatic clear_chan(input int b);
        for (int i = 0; i < 8; i++) mem[b + i] = '0;
    endtask

    bit finished = 0;

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(!bus_req && !done && cp_wready == '0 && cp_rvalid == '0,
              "R10 reset outputs", int'(bus_req), 0);

        // Producer: three items into empty channel (R1, R4, R7)
        push_items(3, 16'h0011);
        idle(40);
        check(wtake == 3, "R4 items taken", wtake, 3);
        check(mem[B0+4] == 16'h11 && mem[B0+5] == 16'h12 && mem[B0+6] == 16'h13,
              "R1 item slots", int'(mem[B0+5]), 16'h12);
        check(mem[B0+2] == 16'd3, "R7 write index", int'(mem[B0+2]), 3);
        check(mem[B0+3] == 16'd3, "R7 fill up", int'(mem[B0+3]), 3);
        check(mem[B0+0] == '0, "R2 lock freed", int'(mem[B0]), 0);
        check(tot[0] == 3, "R8 reported count", tot[0], 3);

        // Fourth item wraps the write index (R7)
        push_items(1, 16'h0014);
        idle(40);
        check(mem[B0+7] == 16'h14, "R7 last slot", int'(mem[B0+7]), 16'h14);
        check(mem[B0+2] == 16'd0, "R7 index wrap", int'(mem[B0+2]), 0);
        check(mem[B0+3] == 16'd4, "R7 fill full", int'(mem[B0+3]), 4);

        // Full channel: offered item never taken, zero-count attempts (R6)
        zero_done[0] = 0;
        @(negedge clk);
        cp_wvalid[0] = 1'b1;
        cp_wdata[DW-1:0] = 16'h00EE;
        idle(150);
        cp_wvalid[0] = 1'b0;
        idle(40);
        check(wtake == 4, "R6 full takes nothing", wtake, 4);
        check(zero_done[0] > 0, "R6 zero-count report", zero_done[0], 1);
        check(mem[B0+3] == 16'd4 && mem[B0+0] == '0, "R6 state kept", int'(mem[B0+3]), 4);

        // Consumer: wrapping read of three items (R5, R7)
        mem[B1+1] = 16'd2; mem[B1+2] = 16'd1; mem[B1+3] = 16'd3;
        mem[B1+6] = 16'h00A2; mem[B1+7] = 16'h00A3; mem[B1+4] = 16'h00A0;
        exp_q.push_back(16'h00A2); exp_q.push_back(16'h00A3); exp_q.push_back(16'h00A0);
        cp_rready[1] = 1'b1;
        idle(120);
        cp_rready[1] = 1'b0;
        idle(40);
        check(rgot == 3 && exp_q.size() == 0, "R5 items delivered", rgot, 3);
        check(mem[B1+1] == 16'd1, "R7 read index wrap", int'(mem[B1+1]), 1);
        check(mem[B1+3] == 16'd0, "R7 fill down", int'(mem[B1+3]), 0);
        check(tot[1] == 3, "R8 consumer count", tot[1], 3);
        check(zero_done[1] > 0, "R6 empty zero-count", zero_done[1], 1);

        // Lock held elsewhere (R2, R3)
        mem[B1+0] = 16'd1; mem[B1+3] = 16'd2;
        mem[B1+5] = 16'h00B1; mem[B1+6] = 16'h00B2;
        last_fail = -1; gap_seen = -1;
        cp_rready[1] = 1'b1;
        idle(120);
        check(rgot == 3, "R2 no access without lock", rgot, 3);
        check(mem[B1+3] == 16'd2 && mem[B1+1] == 16'd1, "R2 state untouched",
              int'(mem[B1+3]), 2);
        check(gap_seen == 19, "R3 retry spacing", gap_seen, 19);
        exp_q.push_back(16'h00B1); exp_q.push_back(16'h00B2);
        mem[B1+0] = '0;
        idle(80);
        cp_rready[1] = 1'b0;
        idle(40);
        check(rgot == 5 && exp_q.size() == 0, "R3 served after release", rgot, 5);
        check(mem[B1+1] == 16'd3 && mem[B1+3] == '0, "R7 after release", int'(mem[B1+1]), 3);

        // Round-robin with both channels pending and nothing to move (R9)
        idle(5);
        dlog.delete();
        cp_wvalid[0] = 1'b1;
        cp_rready[1] = 1'b1;
        idle(300);
        cp_wvalid[0] = 1'b0;
        cp_rready[1] = 1'b0;
        idle(40);
        begin
            int alt_bad = 0;
            for (int i = 1; i < dlog.size() - 1; i++)
                if (dlog[i] == dlog[i-1]) alt_bad++;
            check(dlog.size() >= 6, "R9 attempts made", dlog.size(), 6);
            check(alt_bad == 0, "R9 alternation", alt_bad, 0);
        end
        check(wtake == 4 && rgot == 5, "R9 nothing moved", wtake, 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule